// File: doc/BRIEF.md
# Coherent Byte-Access Sixteen-Bit Timer

This block is a 16-bit up-counter that software reaches through a narrow 8-bit register port. An external count-enable input feeds a small prescaler, which can divide by 1, 2, 4 or 8. While the run bit is set, every terminal count of the prescaler advances the counter by one. When the counter wraps from all ones to zero, it sets a sticky overflow flag. Software clears that flag by writing a one to it.

A mode bit in the control register selects how the high byte is reached. With the mode bit clear, the high-byte address reads and writes the counter's upper byte directly. With it set, the high-byte address reaches a holding register instead:

- Reading the low byte copies the live upper byte into the holding register. A following high-byte read then returns a value that matches the low byte already seen, even if the counter carried in between.
- Writing the high-byte address only fills the holding register.
- A low-byte write then loads both counter bytes in one clock edge.

Only low-byte writes restart the prescaler.

Top module: `tmr_shadow_timer`

## Requirements
- R1: After reset the counter, holding register, prescaler and all control fields are zero. Every read returns 0x00, and any read with the read strobe low also returns 0x00.
- R2: While run (control bit 0) is set, the counter increments once per 2^S cycles in which the count-enable input is high. S is the prescale select in control bits 3:2. While run is clear the counter holds its value.
- R3: An increment from 0xFFFF yields 0x0000 and sets the overflow flag (control bit 7). The flag stays set until a control write with bit 7 equal to one. A control write with bit 7 equal to zero leaves it set.
- R4: With the mode bit (control bit 1) clear, address 1 reads and writes the counter's upper byte directly, and a read of address 0 leaves the holding register unchanged.
- R5: With the mode bit set, a read of address 0 returns the low byte and, at the same clock edge, copies the counter's upper byte into the holding register. Address 1 reads return the holding register.
- R6: With the mode bit set, a write to address 1 updates only the holding register. The counter is unchanged.
- R7: With the mode bit set, a write to address 0 loads the low byte from the write data and the upper byte from the holding register, at the same edge.
- R8: A write to address 1 does not disturb the prescaler's progress.
- R9: A write to address 0 returns the prescaler to zero.
- R10: When a write to a counter byte and an increment fall in the same cycle, the written value is kept and that increment is lost.
- R11: Reads are combinational while the read strobe is high. Address 0 returns the low byte, address 1 the upper byte or the holding register, and address 2 the control word (bit 0 run, bit 1 mode, bits 3:2 prescale select, bit 7 overflow, other bits zero). Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en_i | input | 1 | Count-enable input to the prescaler |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe, acts at the clock edge |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default 8-bit data width and 2-bit prescale select, giving a 16-bit counter and divide ratios up to 8. At this size it can sweep every prescale setting against every pulse count from 0 to 19, and one long burst carries into the upper byte. Presetting the counter to 0xFFFE puts the wrap and the flag's set-and-clear sequence within a few cycles. Switching the mode bit with counter values chosen just below a byte carry brings out the holding-register capture, the direct upper-byte access and the write-over-increment collisions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TA_LO   = 2'd0,
    TA_HI   = 2'd1,
    TA_CTL  = 2'd2,
    TA_NONE = 2'd3
  } tmr_addr_e;

  localparam int unsigned CTL_RUN_BIT  = 0;
  localparam int unsigned CTL_MODE_BIT = 1;
  localparam int unsigned CTL_PS_LSB   = 2;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tc_o
);
  localparam int unsigned PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W:0]   lim;
  logic            term;
  logic            pc_en;

  always_comb begin
    lim   = ((PC_W+1)'(1) << sel_i) - (PC_W+1)'(1);
    term  = ({1'b0, pc_q} >= lim);
    tc_o  = tick_i & term;
    pc_en = clr_i | tick_i;
    pc_d  = pc_q;
    if (clr_i)       pc_d = '0;
    else if (term)   pc_d = '0;
    else             pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic            inc_i,
  input  logic            lo_we_i,
  input  logic            hi_we_i,
  input  logic            hi_from_buf_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   buf_i,
  output logic [2*DW-1:0] cnt_o,
  output logic            wrap_o
);
  localparam int unsigned CW = 2 * DW;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = lo_we_i | hi_we_i | inc_i;
    if (lo_we_i) begin
      cnt_d[DW-1:0] = wdata_i;
      if (hi_from_buf_i) cnt_d[CW-1:DW] = buf_i;
    end else if (hi_we_i) begin
      cnt_d[CW-1:DW] = wdata_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + CW'(1);
    end
    wrap_o = inc_i & ~lo_we_i & ~hi_we_i & (&cnt_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned PS_W = 2
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic [1:0]      addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [2*DW-1:0] cnt_i,
  input  logic            wrap_i,
  output logic [DW-1:0]   rdata_o,
  output logic            run_o,
  output logic            mode_o,
  output logic [PS_W-1:0] sel_o,
  output logic            ovf_o,
  output logic [DW-1:0]   buf_o,
  output logic            lo_we_o,
  output logic            hi_we_o,
  output logic            hi_from_buf_o,
  output logic            pre_clr_o
);
  localparam int unsigned OVF_BIT = DW - 1;

  tmr_addr_e     addr;
  logic          wr_lo, wr_hi, wr_ctl, rd_lo;
  logic          run_q, mode_q, ovf_q, ovf_d;
  logic [PS_W-1:0] sel_q;
  logic [DW-1:0] buf_q, buf_d;
  logic          buf_en, ctl_en, ovf_en;
  logic [DW-1:0] ctl_word;

  assign addr = tmr_addr_e'(addr_i);

  always_comb begin
    wr_lo  = wr_i & (addr == TA_LO);
    wr_hi  = wr_i & (addr == TA_HI);
    wr_ctl = wr_i & (addr == TA_CTL);
    rd_lo  = rd_i & (addr == TA_LO);

    lo_we_o       = wr_lo;
    hi_from_buf_o = wr_lo & mode_q;
    hi_we_o       = wr_hi & ~mode_q;
    pre_clr_o     = wr_lo;

    buf_en = mode_q & (wr_hi | rd_lo);
    buf_d  = wr_hi ? wdata_i : cnt_i[2*DW-1:DW];

    ctl_en = wr_ctl;
    ovf_en = wrap_i | wr_ctl;
    if (wrap_i)                 ovf_d = 1'b1;
    else if (wdata_i[OVF_BIT])  ovf_d = 1'b0;
    else                        ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= '0;
    end else if (ctl_en) begin
      run_q  <= wdata_i[CTL_RUN_BIT];
      mode_q <= wdata_i[CTL_MODE_BIT];
      sel_q  <= wdata_i[CTL_PS_LSB +: PS_W];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  always_comb begin
    ctl_word                        = '0;
    ctl_word[CTL_RUN_BIT]           = run_q;
    ctl_word[CTL_MODE_BIT]          = mode_q;
    ctl_word[CTL_PS_LSB +: PS_W]    = sel_q;
    ctl_word[OVF_BIT]               = ovf_q;
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr)
        TA_LO:   rdata_o = cnt_i[DW-1:0];
        TA_HI:   rdata_o = mode_q ? buf_q : cnt_i[2*DW-1:DW];
        TA_CTL:  rdata_o = ctl_word;
        default: rdata_o = '0;
      endcase
    end
  end

  assign run_o  = run_q;
  assign mode_o = mode_q;
  assign sel_o  = sel_q;
  assign ovf_o  = ovf_q;
  assign buf_o  = buf_q;

endmodule

// File: rtl/tmr_shadow_timer.sv
module tmr_shadow_timer #(
  parameter int unsigned DW   = 8,
  parameter int unsigned PS_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en_i,
  input  logic [1:0]    bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          ovf_o
);
  localparam int unsigned CW = 2 * DW;

  logic [1:0]      rst_sync_q;
  logic            srst_n;
  logic [CW-1:0]   cnt_q;
  logic [DW-1:0]   buf_q;
  logic            run, mode, ovf;
  logic [PS_W-1:0] sel;
  logic            tick, tc, wrap;
  logic            lo_we, hi_we, hi_from_buf, pre_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  assign tick = cnt_en_i & run;

  tmr_prescaler #(.SEL_W(PS_W)) pre_i (
    .clk    (clk),
    .srst_n (srst_n),
    .tick_i (tick),
    .clr_i  (pre_clr),
    .sel_i  (sel),
    .tc_o   (tc)
  );

  tmr_counter #(.DW(DW)) cnt_i (
    .clk           (clk),
    .srst_n        (srst_n),
    .inc_i         (tc),
    .lo_we_i       (lo_we),
    .hi_we_i       (hi_we),
    .hi_from_buf_i (hi_from_buf),
    .wdata_i       (bus_wdata_i),
    .buf_i         (buf_q),
    .cnt_o         (cnt_q),
    .wrap_o        (wrap)
  );

  tmr_regif #(.DW(DW), .PS_W(PS_W)) regs_i (
    .clk           (clk),
    .srst_n        (srst_n),
    .addr_i        (bus_addr_i),
    .wr_i          (bus_wr_i),
    .rd_i          (bus_rd_i),
    .wdata_i       (bus_wdata_i),
    .cnt_i         (cnt_q),
    .wrap_i        (wrap),
    .rdata_o       (bus_rdata_o),
    .run_o         (run),
    .mode_o        (mode),
    .sel_o         (sel),
    .ovf_o         (ovf),
    .buf_o         (buf_q),
    .lo_we_o       (lo_we),
    .hi_we_o       (hi_we),
    .hi_from_buf_o (hi_from_buf),
    .pre_clr_o     (pre_clr)
  );

  assign ovf_o = ovf;

endmodule

// File: rtl/tmr_shadow_timer_chk.sv
module tmr_shadow_timer_chk #(
  parameter int unsigned DW = 8
) (
  input logic            clk,
  input logic            srst_n,
  input logic [1:0]      bus_addr_i,
  input logic            bus_wr_i,
  input logic            bus_rd_i,
  input logic [DW-1:0]   bus_wdata_i,
  input logic [2*DW-1:0] cnt_q,
  input logic [DW-1:0]   buf_q,
  input logic            run,
  input logic            mode,
  input logic            tc,
  input logic            ovf
);
  localparam int unsigned CW = 2 * DW;

  logic wr_lo, wr_hi, wr_ctl, rd_lo;
  assign wr_lo  = bus_wr_i & (bus_addr_i == 2'd0);
  assign wr_hi  = bus_wr_i & (bus_addr_i == 2'd1);
  assign wr_ctl = bus_wr_i & (bus_addr_i == 2'd2);
  assign rd_lo  = bus_rd_i & (bus_addr_i == 2'd0);

  p_step_r2: assert property (@(posedge clk) disable iff (!srst_n)
    tc && !bus_wr_i |=> cnt_q == $past(cnt_q) + CW'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !run && !bus_wr_i |=> $stable(cnt_q));

  p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!srst_n)
    tc && !bus_wr_i && (&cnt_q) |=> ovf && cnt_q == '0);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!srst_n)
    ovf && !(wr_ctl && bus_wdata_i[DW-1]) |=> ovf);

  p_direct_hi_r4: assert property (@(posedge clk) disable iff (!srst_n)
    !mode && wr_hi |=> cnt_q[CW-1:DW] == $past(bus_wdata_i) && $stable(buf_q));

  p_capture_r5: assert property (@(posedge clk) disable iff (!srst_n)
    mode && rd_lo && !bus_wr_i |=> buf_q == $past(cnt_q[CW-1:DW]));

  p_buf_only_r6: assert property (@(posedge clk) disable iff (!srst_n)
    mode && wr_hi && !tc |=> buf_q == $past(bus_wdata_i) && $stable(cnt_q));

  p_joint_load_r7: assert property (@(posedge clk) disable iff (!srst_n)
    mode && wr_lo |=> cnt_q == {$past(buf_q), $past(bus_wdata_i)});

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !mode && wr_lo && tc |=> cnt_q[DW-1:0] == $past(bus_wdata_i));

endmodule

bind tmr_shadow_timer tmr_shadow_timer_chk #(.DW(DW)) chk_i (
  .clk         (clk),
  .srst_n      (srst_n),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wdata_i (bus_wdata_i),
  .cnt_q       (cnt_q),
  .buf_q       (buf_q),
  .run         (run),
  .mode        (mode),
  .tc          (tc),
  .ovf         (ovf)
);

// File: tb/tmr_shadow_timer_tb_top.sv
`timescale 1ns/1ps
module tmr_shadow_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2, A_NONE = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_shadow_timer dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en_i    (cnt_en),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .ovf_o       (ovf)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit en = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; cnt_en = en;
    @(negedge clk);
    wr = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulses(input int n);
    if (n > 0) begin
      @(negedge clk);
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  function automatic logic [7:0] ctl(input bit run, input bit mode, input int sel);
    return {4'b0000, 2'(sel), mode, run};
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, R11: strobe-less read is zero
    bus_rd(A_LO, v);  check("R1 lo", v, 8'h00);
    bus_rd(A_HI, v);  check("R1 hi", v, 8'h00);
    bus_rd(A_CTL, v); check("R1 ctl", v, 8'h00);
    #1 check("R1 idle rdata", rdata, 8'h00);

    // R2: sweep prescale settings and pulse counts
    for (int sel = 0; sel < 4; sel++) begin
      bus_wr(A_CTL, ctl(1, 0, sel));
      for (int n = 0; n < 20; n++) begin
        bus_wr(A_HI, 8'h00);
        bus_wr(A_LO, 8'h00);
        pulses(n);
        bus_rd(A_LO, v);
        check($sformatf("R2 sel%0d n%0d", sel, n), v, 8'(n >> sel));
      end
      bus_wr(A_CTL, ctl(0, 0, sel));
      pulses(8);
      bus_rd(A_LO, v);
      check($sformatf("R2 hold sel%0d", sel), v, 8'(19 >> sel));
    end
    // R2: carry into upper byte
    bus_wr(A_CTL, ctl(1, 0, 0));
    bus_wr(A_HI, 8'h00);
    bus_wr(A_LO, 8'h00);
    pulses(300);
    bus_rd(A_LO, v); check("R2 long lo", v, 8'h2C);
    bus_rd(A_HI, v); check("R2 long hi", v, 8'h01);

    // R3: wrap and sticky flag
    bus_wr(A_HI, 8'hFF);
    bus_wr(A_LO, 8'hFE);
    pulses(1);
    bus_rd(A_LO, v);  check("R3 pre-wrap lo", v, 8'hFF);
    bus_rd(A_CTL, v); check("R3 flag clear", v, 8'h01);
    pulses(1);
    bus_rd(A_LO, v);  check("R3 wrap lo", v, 8'h00);
    bus_rd(A_HI, v);  check("R3 wrap hi", v, 8'h00);
    bus_rd(A_CTL, v); check("R3 flag set", v, 8'h81);
    #1 check("R3 ovf pin", {7'd0, ovf}, 8'h01);
    pulses(2);
    bus_wr(A_CTL, 8'h01);
    bus_rd(A_CTL, v); check("R3 sticky", v, 8'h81);
    bus_wr(A_CTL, 8'h81);
    bus_rd(A_CTL, v); check("R3 w1c", v, 8'h01);

    // R8/R9: prescaler clearing rules, ratio 4
    bus_wr(A_CTL, ctl(1, 0, 2));
    bus_wr(A_HI, 8'h00);
    bus_wr(A_LO, 8'h00);
    pulses(3);
    bus_rd(A_LO, v); check("R8 partial", v, 8'h00);
    bus_wr(A_HI, 8'h00);
    pulses(1);
    bus_rd(A_LO, v); check("R8 hi write keeps prescaler", v, 8'h01);
    pulses(3);
    bus_wr(A_LO, 8'h10);
    pulses(1);
    bus_rd(A_LO, v); check("R9 lo write clears prescaler", v, 8'h10);
    pulses(3);
    bus_rd(A_LO, v); check("R9 full period", v, 8'h11);

    // R10: write collides with increment
    bus_wr(A_CTL, ctl(1, 0, 0));
    bus_wr(A_LO, 8'h40, 1'b1);
    bus_rd(A_LO, v); check("R10 lo write wins", v, 8'h40);
    bus_wr(A_HI, 8'h01, 1'b1);
    bus_rd(A_LO, v); check("R10 hi write drops inc lo", v, 8'h40);
    bus_rd(A_HI, v); check("R10 hi write drops inc hi", v, 8'h01);

    // R4: direct mode, no capture on low read
    bus_wr(A_CTL, ctl(0, 1, 0));
    bus_wr(A_HI, 8'h33);
    bus_wr(A_CTL, ctl(0, 0, 0));
    bus_wr(A_HI, 8'h77);
    bus_rd(A_HI, v); check("R4 direct hi", v, 8'h77);
    bus_rd(A_LO, v);
    bus_wr(A_CTL, ctl(0, 1, 0));
    bus_rd(A_HI, v); check("R4 buffer untouched", v, 8'h33);

    // R5: coherent read across a carry
    bus_wr(A_CTL, ctl(1, 1, 0));
    bus_wr(A_HI, 8'h12);
    bus_wr(A_LO, 8'hFF);
    bus_rd(A_LO, v); check("R5 lo", v, 8'hFF);
    pulses(1);
    bus_rd(A_HI, v); check("R5 captured hi", v, 8'h12);
    bus_rd(A_LO, v); check("R5 lo after carry", v, 8'h00);
    bus_rd(A_HI, v); check("R5 recaptured hi", v, 8'h13);

    // R6: buffered high write leaves counter alone
    bus_wr(A_HI, 8'hAB);
    bus_rd(A_HI, v); check("R6 buffer", v, 8'hAB);
    bus_rd(A_LO, v); check("R6 lo unchanged", v, 8'h00);
    bus_rd(A_HI, v); check("R6 hi unchanged", v, 8'h13);

    // R7: joint load, also against an increment (R10)
    bus_wr(A_HI, 8'h22);
    bus_wr(A_LO, 8'h05, 1'b1);
    bus_rd(A_LO, v); check("R7 lo", v, 8'h05);
    bus_rd(A_HI, v); check("R7 hi", v, 8'h22);
    bus_wr(A_CTL, ctl(0, 0, 0));
    bus_rd(A_HI, v); check("R7 hi direct", v, 8'h22);

    // R11: map
    bus_rd(A_NONE, v); check("R11 addr3", v, 8'h00);
    bus_wr(A_CTL, 8'h0E);
    bus_rd(A_CTL, v);  check("R11 ctl fields", v, 8'h0E);

    done = 1'b1;
    report();
  end

endmodule